// File: doc/BRIEF.md
# GPIO Port with Transition Interrupts

This block is one eight-pin general-purpose I/O port that software controls through a small register file. Each pin has a direction bit, a polarity-inversion bit and an output-style bit. The style bit chooses between holding the latch value on the pin and sending a short fixed-length pulse each time a one is written. The port synchronises its pin inputs. It records every input transition in a status register that clears when read, and it keeps a snapshot of the raw pin levels taken while reset is applied.

The block also contains the interrupt generator. The generator combines the enabled status bits into one request. It can present that request as a level or as repeating pulses, with a programmable idle polarity. When routing is enabled, the request is driven out on one nominated port pin. An external reset input can optionally restore the port registers and re-take the snapshot, depending on the mode register. The mode register is never reset by the external reset.

Register indices: 0x00 input data, 0x01 output latch, 0x02 polarity, 0x03 direction, 0x04 output style, 0x05 snapshot, 0x10 transition status, 0x12 interrupt enable, 0x14 mode. Any other index reads 0.

Top module: `gpio_irq_port`

## Requirements
- R1: After power-on reset, the registers read as follows: latch 0x00, polarity 0xF0, direction 0xFF, style 0x00, status 0x00, enable 0x00, mode 0x00. All output enables are 0.
- R2: A direction bit of 1 makes the pin an input (pin_oe low). A direction bit of 0 drives the pin (pin_oe high).
- R3: With style bit 0, pin_out carries latch XOR polarity. Index 0x00 returns the synchronised pin level XOR polarity. Index 0x01 returns the latch as written.
- R4: With style bit 1, writing 1 to that latch bit makes pin_out show NOT polarity for exactly PULSE_LEN clocks. After the pulse, pin_out returns to the polarity value.
- R5: Index 0x05 holds the raw pin levels sampled while power-on reset is asserted. The external reset re-samples them only when mode bit 0 is set.
- R6: Any transition on a synchronised input sets its bit at index 0x10. A read strobe at 0x10 clears the whole register. A transition that lands in the same cycle as that read remains set.
- R7: With mode bit 7 set, pin IRQ_PIN is forced to output and carries the interrupt, and its status bit always reads 0.
- R8: In level mode (mode bit 5 = 0), the interrupt is active while (status AND enable) is non-zero, and it drops when status is read. Mode bit 4 = 1 selects idle-high, in which case active is low. Mode bit 4 = 0 selects idle-low, in which case active is high.
- R9: In pulse mode (mode bit 5 = 1), a pending enabled status fires an active pulse of PULSE_LEN clocks. The pulse repeats every REFIRE clocks while the status stays pending. No further pulse follows once the status is read.
- R10: The external reset with mode bit 2 set restores latch, polarity, direction, style, status and enable to their reset values. With bit 2 clear it leaves them unchanged. It never changes the mode register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| ext_rst | input | 1 | Synchronous external reset, active high, effect chosen by mode bits 2 and 0 |
| reg_idx | input | 5 | Register index |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe (clears status at 0x10) |
| reg_rdata | output | 8 | Read data for reg_idx, combinational |
| pin_in | input | 8 | Pin levels from pads |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables |

## Verification
The bench builds the block with PULSE_LEN = 4 and REFIRE = 32, and keeps IRQ_PIN at 7. These short values let the bench measure the exact pulse width of both the pin pulse and the interrupt pulse. They also let it count interrupt re-fires across two full periods and confirm silence after the status read, all within a few hundred cycles. The bench drives random values for polarity, direction, latch and pin input. Directed steps cover the same-cycle transition-and-read race, the enable mask, both idle polarities and both external-reset settings.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int PORT_W = 8;
    localparam int IDX_W  = 5;

    typedef logic [PORT_W-1:0] port_t;
    typedef logic [IDX_W-1:0]  idx_t;

    localparam idx_t IX_IN   = 5'h00;
    localparam idx_t IX_OUT  = 5'h01;
    localparam idx_t IX_POL  = 5'h02;
    localparam idx_t IX_DIR  = 5'h03;
    localparam idx_t IX_STY  = 5'h04;
    localparam idx_t IX_SNAP = 5'h05;
    localparam idx_t IX_STAT = 5'h10;
    localparam idx_t IX_IEN  = 5'h12;
    localparam idx_t IX_MODE = 5'h14;

    localparam port_t POL_RST = 8'hF0;
    localparam port_t DIR_RST = 8'hFF;

    typedef struct packed {
        logic irq_route;
        logic rsv6;
        logic irq_pulse;
        logic idle_high;
        logic rsv3;
        logic ext_port_rst;
        logic rsv1;
        logic ext_snap;
    } mode_t;

    typedef struct packed {
        port_t latch;
        port_t pol;
        port_t dir;
        port_t style;
        port_t ien;
    } port_cfg_t;

    localparam port_cfg_t CFG_RST = '{latch: '0, pol: POL_RST, dir: DIR_RST,
                                      style: '0, ien: '0};

    function automatic logic irq_pin_level(logic active, logic idle_high);
        return active ^ idle_high;
    endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync
    import gpio_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  port_t pin_i,
    output port_t level_o,
    output port_t edge_o
);
    port_t s1_q, s2_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q   <= pin_i;
            s2_q   <= pin_i;
            prev_q <= pin_i;
        end else begin
            s1_q   <= pin_i;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    assign level_o = s2_q;
    assign edge_o  = s2_q ^ prev_q;
endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive
    import gpio_irq_pkg::*;
#(
    parameter int PULSE_LEN = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  port_cfg_t cfg,
    input  port_t     fire,
    output port_t     out_o,
    output port_t     oe_o
);
    localparam int CW = $clog2(PULSE_LEN + 1);

    for (genvar g = 0; g < PORT_W; g++) begin : g_pin
        logic [CW-1:0] cnt_q;
        logic          act;

        always_ff @(posedge clk) begin
            if (rst || clr)          cnt_q <= '0;
            else if (fire[g])        cnt_q <= CW'(PULSE_LEN);
            else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
        end

        assign act      = (cnt_q != '0);
        assign out_o[g] = cfg.style[g] ? (cfg.pol[g] ^ act) : (cfg.latch[g] ^ cfg.pol[g]);
        assign oe_o[g]  = ~cfg.dir[g];

        // R4
        pulse_start_chk: assert property (@(posedge clk) disable iff (rst || clr)
            (fire[g] && cfg.style[g]) |=> (!cfg.style[g] || out_o[g] == ~cfg.pol[g]));
    end
endmodule

// File: rtl/gpio_irq_gen.sv
module gpio_irq_gen
    import gpio_irq_pkg::*;
#(
    parameter int PULSE_LEN = 16,
    parameter int REFIRE    = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic pending,
    input  logic pulse_mode,
    input  logic idle_high,
    output logic irq_o
);
    localparam int CW = $clog2(PULSE_LEN + 1);
    localparam int TW = $clog2(REFIRE + 1);

    logic [CW-1:0] pcnt_q;
    logic [TW-1:0] timer_q;
    logic          pulse_act;
    logic          active;

    always_ff @(posedge clk) begin
        if (rst || !pulse_mode) begin
            pcnt_q  <= '0;
            timer_q <= '0;
        end else if (!pending) begin
            timer_q <= '0;
            if (pcnt_q != '0) pcnt_q <= pcnt_q - 1'b1;
        end else if (timer_q == '0) begin
            pcnt_q  <= CW'(PULSE_LEN);
            timer_q <= TW'(REFIRE - 1);
        end else begin
            timer_q <= timer_q - 1'b1;
            if (pcnt_q != '0) pcnt_q <= pcnt_q - 1'b1;
        end
    end

    assign pulse_act = (pcnt_q != '0);
    assign active    = pulse_mode ? pulse_act : pending;
    assign irq_o     = irq_pin_level(active, idle_high);

    // R8
    lvl_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (!pulse_mode && pending) |-> (irq_o != idle_high));

    // R9
    pulse_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pulse_mode && $rose(pulse_act)) |=> (pulse_act || !pulse_mode));
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int PULSE_LEN = 16,
    parameter int REFIRE    = 1024,
    parameter int IRQ_PIN   = 7
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ext_rst,
    input  logic [4:0] reg_idx,
    input  logic [7:0] reg_wdata,
    input  logic       reg_we,
    input  logic       reg_re,
    output logic [7:0] reg_rdata,
    input  logic [7:0] pin_in,
    output logic [7:0] pin_out,
    output logic [7:0] pin_oe
);
    port_cfg_t cfg_q;
    port_t     status_q, snap_q;
    mode_t     mode_q;
    port_t     level, edges, edge_m, shr_m, fire, drv_out, drv_oe;
    logic      port_clr, stat_rd, pending, irq_lvl;

    assign port_clr = ext_rst && mode_q.ext_port_rst;
    assign stat_rd  = reg_re && (reg_idx == IX_STAT);
    assign shr_m    = mode_q.irq_route ? (port_t'(1) << IRQ_PIN) : '0;
    assign edge_m   = edges & ~shr_m;
    assign fire     = (reg_we && reg_idx == IX_OUT && !port_clr) ? (reg_wdata & cfg_q.style) : '0;
    assign pending  = |(status_q & ~shr_m & cfg_q.ien);

    gpio_in_sync u_sync (
        .clk(clk), .rst(rst), .pin_i(pin_in), .level_o(level), .edge_o(edges)
    );

    gpio_pin_drive #(.PULSE_LEN(PULSE_LEN)) u_drive (
        .clk(clk), .rst(rst), .clr(port_clr), .cfg(cfg_q), .fire(fire),
        .out_o(drv_out), .oe_o(drv_oe)
    );

    gpio_irq_gen #(.PULSE_LEN(PULSE_LEN), .REFIRE(REFIRE)) u_irq (
        .clk(clk), .rst(rst), .pending(pending), .pulse_mode(mode_q.irq_pulse),
        .idle_high(mode_q.idle_high), .irq_o(irq_lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= CFG_RST;
            status_q <= '0;
            mode_q   <= '0;
        end else begin
            if (port_clr) begin
                cfg_q    <= CFG_RST;
                status_q <= '0;
            end else begin
                status_q <= (stat_rd ? '0 : (status_q & ~shr_m)) | edge_m;
                if (reg_we) begin
                    case (reg_idx)
                        IX_OUT:  cfg_q.latch <= reg_wdata;
                        IX_POL:  cfg_q.pol   <= reg_wdata;
                        IX_DIR:  cfg_q.dir   <= reg_wdata;
                        IX_STY:  cfg_q.style <= reg_wdata;
                        IX_IEN:  cfg_q.ien   <= reg_wdata;
                        default: ;
                    endcase
                end
            end
            if (reg_we && reg_idx == IX_MODE) mode_q <= mode_t'(reg_wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || (ext_rst && mode_q.ext_snap)) snap_q <= pin_in;
    end

    always_comb begin
        pin_out = drv_out;
        pin_oe  = drv_oe;
        if (mode_q.irq_route) begin
            pin_out[IRQ_PIN] = irq_lvl;
            pin_oe[IRQ_PIN]  = 1'b1;
        end
    end

    always_comb begin
        case (reg_idx)
            IX_IN:   reg_rdata = level ^ cfg_q.pol;
            IX_OUT:  reg_rdata = cfg_q.latch;
            IX_POL:  reg_rdata = cfg_q.pol;
            IX_DIR:  reg_rdata = cfg_q.dir;
            IX_STY:  reg_rdata = cfg_q.style;
            IX_SNAP: reg_rdata = snap_q;
            IX_STAT: reg_rdata = status_q & ~shr_m;
            IX_IEN:  reg_rdata = cfg_q.ien;
            IX_MODE: reg_rdata = mode_q;
            default: reg_rdata = '0;
        endcase
    end

    // R6
    stat_set_chk: assert property (@(posedge clk) disable iff (rst || port_clr)
        (edge_m != '0) |=> ((status_q & $past(edge_m)) == $past(edge_m)));

    // R6
    stat_clr_chk: assert property (@(posedge clk) disable iff (rst || port_clr)
        stat_rd |=> ((status_q & ~$past(edge_m)) == '0));

    // R7
    shr_oe_chk: assert property (@(posedge clk) disable iff (rst)
        mode_q.irq_route |-> pin_oe[IRQ_PIN]);
endmodule

// File: tb/gpio_irq_port_tb.sv
`timescale 1ns/1ps
module gpio_irq_port_tb_top;
    localparam int P_LEN = 4;
    localparam int P_REF = 32;
    localparam int IRQ   = 7;

    logic       clk = 1'b0;
    logic       rst, ext_rst, reg_we, reg_re;
    logic [4:0] reg_idx;
    logic [7:0] reg_wdata, reg_rdata, pin_in, pin_out, pin_oe;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    gpio_irq_port #(.PULSE_LEN(P_LEN), .REFIRE(P_REF), .IRQ_PIN(IRQ)) dut_i (
        .clk(clk), .rst(rst), .ext_rst(ext_rst), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
        .reg_rdata(reg_rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    function automatic logic [7:0] exp_level(logic [7:0] lat, logic [7:0] pol);
        return lat ^ pol;
    endfunction

    function automatic logic [7:0] exp_oe(logic [7:0] dir);
        return ~dir;
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=0x%0h exp=0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(logic [4:0] idx, logic [7:0] d);
        @(negedge clk);
        reg_idx = idx; reg_wdata = d; reg_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [4:0] idx, output logic [7:0] d);
        @(negedge clk);
        reg_idx = idx; reg_re = 1'b1;
        #1 d = reg_rdata;
        @(posedge clk);
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ext_pulse();
        @(negedge clk);
        ext_rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ext_rst = 1'b0;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog got=timeout exp=finish");
            summary();
        end
    end

    initial begin
        logic [7:0] d, pol, dir, lat, pv;
        int seed_v, rises, highs;
        bit prev;
        seed_v = $urandom(32'h5EED_0601);
        rst = 1'b1; ext_rst = 1'b0; reg_we = 1'b0; reg_re = 1'b0;
        reg_idx = '0; reg_wdata = '0; pin_in = 8'h5A;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        rd(5'h01, d); chk("R1 latch", d, 8'h00);
        rd(5'h02, d); chk("R1 pol", d, 8'hF0);
        rd(5'h03, d); chk("R1 dir", d, 8'hFF);
        rd(5'h04, d); chk("R1 style", d, 8'h00);
        rd(5'h10, d); chk("R1 status", d, 8'h00);
        rd(5'h12, d); chk("R1 ien", d, 8'h00);
        rd(5'h14, d); chk("R1 mode", d, 8'h00);
        chk("R1 oe", pin_oe, 8'h00);
        // R5 snapshot during power-on reset
        rd(5'h05, d); chk("R5 snap", d, 8'h5A);

        // R2 R3 random configuration
        for (int i = 0; i < 16; i++) begin
            pol = 8'($urandom); dir = 8'($urandom); lat = 8'($urandom);
            wr(5'h02, pol); wr(5'h03, dir); wr(5'h01, lat);
            chk("R2 oe", pin_oe, exp_oe(dir));
            chk("R3 out", pin_out, exp_level(lat, pol));
            rd(5'h01, d); chk("R3 latch rd", d, lat);
            pin_in = 8'($urandom);
            wait_n(3);
            rd(5'h00, d); chk("R3 in rd", d, pin_in ^ pol);
        end

        // R6 set and clear on read
        rd(5'h10, d);
        pin_in = pin_in ^ 8'h3C;
        wait_n(4);
        rd(5'h10, d); chk("R6 set", d, 8'h3C);
        rd(5'h10, d); chk("R6 cleared", d, 8'h00);

        // R6 transition coinciding with status read
        pin_in = pin_in ^ 8'h81;
        @(posedge clk); @(posedge clk); @(negedge clk);
        reg_idx = 5'h10; reg_re = 1'b1;
        #1 d = reg_rdata;
        chk("R6 race old", d, 8'h00);
        @(posedge clk); @(negedge clk);
        reg_re = 1'b0;
        rd(5'h10, d); chk("R6 race kept", d, 8'h81);

        // R4 pulse style output
        wr(5'h03, 8'h00); wr(5'h02, 8'h00); wr(5'h01, 8'h00); wr(5'h04, 8'h02);
        wr(5'h01, 8'h02);
        highs = 0;
        for (int k = 0; k < P_LEN + 4; k++) begin
            if (pin_out[1]) highs++;
            @(negedge clk);
        end
        chk("R4 pulse len pol0", highs, P_LEN);
        chk("R4 idle pol0", pin_out[1], 1'b0);
        wr(5'h02, 8'h02);
        chk("R4 idle pol1", pin_out[1], 1'b1);
        wr(5'h01, 8'h02);
        highs = 0;
        for (int k = 0; k < P_LEN + 4; k++) begin
            if (!pin_out[1]) highs++;
            @(negedge clk);
        end
        chk("R4 pulse len pol1", highs, P_LEN);
        wr(5'h04, 8'h00); wr(5'h02, 8'h00); wr(5'h03, 8'hFF);

        // R7 R8 level interrupt, idle low
        wr(5'h12, 8'h01); wr(5'h14, 8'h80);
        rd(5'h10, d);
        chk("R7 oe", pin_oe[IRQ], 1'b1);
        chk("R8 idle low", pin_out[IRQ], 1'b0);
        pin_in = pin_in ^ 8'h81;
        wait_n(4);
        chk("R8 active", pin_out[IRQ], 1'b1);
        rd(5'h10, d); chk("R7 masked status", d, 8'h01);
        chk("R8 dropped on read", pin_out[IRQ], 1'b0);
        // R8 enable mask
        pin_in = pin_in ^ 8'h02;
        wait_n(4);
        chk("R8 masked", pin_out[IRQ], 1'b0);
        rd(5'h10, d); chk("R8 masked status", d, 8'h02);
        // R8 idle high
        wr(5'h14, 8'h90);
        chk("R8 idle high", pin_out[IRQ], 1'b1);
        pin_in = pin_in ^ 8'h01;
        wait_n(4);
        chk("R8 active low", pin_out[IRQ], 1'b0);
        rd(5'h10, d);
        chk("R8 release high", pin_out[IRQ], 1'b1);

        // R9 pulse interrupt with re-fire
        wr(5'h14, 8'hA0);
        pin_in = pin_in ^ 8'h01;
        for (int k = 0; k < 12 && !pin_out[IRQ]; k++) @(negedge clk);
        chk("R9 first pulse", pin_out[IRQ], 1'b1);
        rises = 0; highs = 0; prev = 1'b0;
        for (int k = 0; k < 2 * P_REF; k++) begin
            if (pin_out[IRQ]) highs++;
            if (pin_out[IRQ] && !prev) rises++;
            prev = pin_out[IRQ];
            @(negedge clk);
        end
        chk("R9 refire count", rises, 2);
        chk("R9 pulse width", highs, 2 * P_LEN);
        rd(5'h10, d); chk("R9 status", d, 8'h01);
        wait_n(P_LEN + 2);
        highs = 0;
        for (int k = 0; k < 2 * P_REF; k++) begin
            if (pin_out[IRQ]) highs++;
            @(negedge clk);
        end
        chk("R9 silent after read", highs, 0);

        // R10 R5 external reset enabled
        wr(5'h14, 8'h05); wr(5'h02, 8'h33); wr(5'h12, 8'h0F);
        pv = 8'hC3; pin_in = pv;
        wait_n(3);
        ext_pulse();
        rd(5'h02, d); chk("R10 pol restored", d, 8'hF0);
        rd(5'h12, d); chk("R10 ien restored", d, 8'h00);
        rd(5'h14, d); chk("R10 mode kept", d, 8'h05);
        rd(5'h05, d); chk("R5 ext snap", d, pv);
        // R10 R5 external reset disabled
        wr(5'h14, 8'h00); wr(5'h02, 8'h33);
        pin_in = 8'h11;
        wait_n(3);
        ext_pulse();
        rd(5'h02, d); chk("R10 pol kept", d, 8'h33);
        rd(5'h05, d); chk("R5 snap kept", d, pv);

        done = 1;
        summary();
    end
endmodule